// File: doc/BRIEF.md
# Move-Only Transport Datapath

This block is a small processor core with one kind of instruction: a data move from a source port to a destination port. Every instruction word carries four move slots, and all of them execute in the same clock cycle. There are no opcodes. All arithmetic happens because a value was moved into a functional unit's trigger port. The address of that trigger port selects which operation the unit performs.

The core has eight general registers, two ALUs and a load/store unit. Each ALU has a latched first operand (operand A) and a group of eight trigger ports, one per operation. The value moved into a trigger port becomes operand B, and the operation starts. The load/store unit has a latched address operand and two trigger ports, one for store and one for load. Every unit keeps its last result in a result port. Any later move can read that result port, either into a register or straight into another unit's operand port (software bypassing).

The surrounding system provides one instruction per clock cycle on `instr_i`. An all-zero word is a no-operation. It also serves a data memory that reads combinationally, and it can look at any register through a combinational debug read port.

Top module: `tta_core`

## Requirements
- R1: After an asynchronous reset (`rst_ni` low), all registers, operand latches and result ports read 0.
- R2: One instruction is consumed at each rising clock edge. Move slot s occupies `instr_i[13*s+12 : 13*s]`: bit 12 is the valid bit, bits 11:6 are the source id and bits 5:0 are the destination id. A slot whose valid bit is 0 has no effect.
- R3: The source id selects the value as follows. Ids 0..7 read a register. Id 8 reads the first ALU result, id 9 the second ALU result and id 10 the load/store result. Ids 32..63 give the immediate `id[4:0]`, zero-extended. Every other source id reads 0.
- R4: Destination ids 0..7 write a register. Every read within an instruction sees the values from before that instruction's writes, so two crossed moves swap two registers.
- R5: Destination 8 is the first ALU's operand A and destinations 16+op trigger it. Destination 9 is the second ALU's operand A and destinations 24+op trigger it. The trigger value is operand B. The op codes are: 0 add, 1 A-B, 2 and, 3 or, 4 xor, 5 A<<B[4:0], 6 logical A>>B[4:0], 7 unsigned A<B (result 1 or 0).
- R6: A trigger uses operand A as it stands after the same instruction's operand moves. Operand A keeps its value across later instructions until it is written again.
- R7: A result port takes its new value at the edge that ends the trigger instruction. It holds that value until the unit is triggered again. A later instruction can move the result into a register or directly into another unit's operand port.
- R8: When several valid slots in one instruction write the same destination, the highest-numbered slot wins. Likewise, when several slots trigger the same unit, the highest-numbered trigger decides both the operation and operand B.
- R9: Destination 10 is the load/store address operand. Destination 32 stores: during that instruction the core drives `mem_we_o`=1, `mem_addr_o`= the address operand (after same-instruction forwarding) and `mem_wdata_o`= the moved value. Destination 33 loads: during that instruction the core drives `mem_re_o`=1 and `mem_addr_o`= the moved value, and the load result takes `mem_rdata_i` at the edge. Store and load are never both active.
- R10: `dbg_data_o` shows, combinationally, the register selected by `dbg_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 52 | Four move slots, slot 0 in the low bits |
| mem_addr_o | output | 32 | Data memory address |
| mem_wdata_o | output | 32 | Store data |
| mem_we_o | output | 1 | Store strobe |
| mem_re_o | output | 1 | Load strobe |
| mem_rdata_i | input | 32 | Combinational load data |
| dbg_addr_i | input | 3 | Debug register select |
| dbg_data_o | output | 32 | Debug register value |

## Verification
The hardest cases to reach are those where one instruction both changes state and depends on it. Examples are a trigger whose operand A is written in the same instruction, a register swap, and conflicting writes to one destination or one unit's triggers. The stimulus builds these directly as multi-slot instruction words. The bench then drains the results into registers and reads them back through the debug port. It also chains operations so that each instruction reads the previous result while starting the next operation. This exercises result ports being read and written in the same cycle, and bypassing from one unit into the other.

// File: rtl/tta_pkg.sv
package tta_pkg;
  localparam int ID_W   = 6;
  localparam int SLOT_W = 1 + 2 * ID_W;

  typedef enum logic [2:0] {
    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_SHL, OP_SHR, OP_SLTU
  } alu_op_e;

  localparam logic [ID_W-1:0] SRC_ALU0  = 6'd8;
  localparam logic [ID_W-1:0] SRC_ALU1  = 6'd9;
  localparam logic [ID_W-1:0] SRC_LSU   = 6'd10;

  localparam logic [ID_W-1:0] DST_OPA0  = 6'd8;
  localparam logic [ID_W-1:0] DST_OPA1  = 6'd9;
  localparam logic [ID_W-1:0] DST_LADDR = 6'd10;
  localparam logic [ID_W-1:0] DST_TRG0  = 6'd16;
  localparam logic [ID_W-1:0] DST_TRG1  = 6'd24;
  localparam logic [ID_W-1:0] DST_STORE = 6'd32;
  localparam logic [ID_W-1:0] DST_LOAD  = 6'd33;
endpackage

// File: rtl/tta_rf.sv
module tta_rf #(
  parameter int NREG  = 8,
  parameter int DW    = 32,
  parameter int SLOTS = 4,
  localparam int AW   = $clog2(NREG)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     slot_vld_i [SLOTS],
  input  logic [tta_pkg::ID_W-1:0] slot_dst_i [SLOTS],
  input  logic [DW-1:0]            slot_val_i [SLOTS],
  input  logic [AW-1:0]            rd_addr_i  [SLOTS],
  output logic [DW-1:0]            rd_data_o  [SLOTS],
  input  logic [AW-1:0]            dbg_addr_i,
  output logic [DW-1:0]            dbg_data_o
);
  logic [DW-1:0] regs_q [NREG];
  logic [DW-1:0] regs_d [NREG];

  // later slots override earlier ones
  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      regs_d[r] = regs_q[r];
      for (int s = 0; s < SLOTS; s++)
        if (slot_vld_i[s] && slot_dst_i[s] == tta_pkg::ID_W'(r))
          regs_d[r] = slot_val_i[s];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREG; r++) regs_q[r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) regs_q[r] <= regs_d[r];
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_rd
    assign rd_data_o[g] = regs_q[rd_addr_i[g]];
  end

  assign dbg_data_o = regs_q[dbg_addr_i];
endmodule

// File: rtl/tta_src_mux.sv
module tta_src_mux #(
  parameter int NREG = 8,
  parameter int DW   = 32
) (
  input  logic [tta_pkg::ID_W-1:0] src_i,
  input  logic [DW-1:0]            reg_i,
  input  logic [DW-1:0]            alu0_i,
  input  logic [DW-1:0]            alu1_i,
  input  logic [DW-1:0]            lsu_i,
  output logic [DW-1:0]            val_o
);
  import tta_pkg::*;
  localparam int IMM_W = ID_W - 1;

  always_comb begin
    if (src_i[ID_W-1])                  val_o = DW'(src_i[IMM_W-1:0]);
    else if (src_i < ID_W'(NREG))       val_o = reg_i;
    else if (src_i == SRC_ALU0)         val_o = alu0_i;
    else if (src_i == SRC_ALU1)         val_o = alu1_i;
    else if (src_i == SRC_LSU)          val_o = lsu_i;
    else                                val_o = '0;
  end
endmodule

// File: rtl/tta_fu_alu.sv
module tta_fu_alu #(
  parameter int                        DW     = 32,
  parameter int                        SLOTS  = 4,
  parameter logic [tta_pkg::ID_W-1:0] OPA_ID = 6'd8,
  parameter logic [tta_pkg::ID_W-1:0] TRG_ID = 6'd16,
  localparam int                       SHW    = $clog2(DW)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     slot_vld_i [SLOTS],
  input  logic [tta_pkg::ID_W-1:0] slot_dst_i [SLOTS],
  input  logic [DW-1:0]            slot_val_i [SLOTS],
  output logic                     trg_o,
  output logic [DW-1:0]            res_o
);
  import tta_pkg::*;

  logic [DW-1:0] opa_q, opa_d, opb, res_q, res_d;
  alu_op_e       op;
  logic          trg;

  always_comb begin
    opa_d = opa_q;
    trg   = 1'b0;
    op    = OP_ADD;
    opb   = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (slot_vld_i[s] && slot_dst_i[s] == OPA_ID) opa_d = slot_val_i[s];
      if (slot_vld_i[s] && slot_dst_i[s][ID_W-1:3] == TRG_ID[ID_W-1:3]) begin
        trg = 1'b1;
        op  = alu_op_e'(slot_dst_i[s][2:0]);
        opb = slot_val_i[s];
      end
    end
  end

  always_comb begin
    unique case (op)
      OP_ADD:  res_d = opa_d + opb;
      OP_SUB:  res_d = opa_d - opb;
      OP_AND:  res_d = opa_d & opb;
      OP_OR:   res_d = opa_d | opb;
      OP_XOR:  res_d = opa_d ^ opb;
      OP_SHL:  res_d = opa_d << opb[SHW-1:0];
      OP_SHR:  res_d = opa_d >> opb[SHW-1:0];
      OP_SLTU: res_d = DW'(opa_d < opb);
      default: res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opa_q <= '0;
      res_q <= '0;
    end else begin
      opa_q <= opa_d;
      if (trg) res_q <= res_d;
    end
  end

  assign trg_o = trg;
  assign res_o = res_q;
endmodule

// File: rtl/tta_fu_lsu.sv
module tta_fu_lsu #(
  parameter int DW    = 32,
  parameter int SLOTS = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     slot_vld_i [SLOTS],
  input  logic [tta_pkg::ID_W-1:0] slot_dst_i [SLOTS],
  input  logic [DW-1:0]            slot_val_i [SLOTS],
  output logic [DW-1:0]            mem_addr_o,
  output logic [DW-1:0]            mem_wdata_o,
  output logic                     mem_we_o,
  output logic                     mem_re_o,
  input  logic [DW-1:0]            mem_rdata_i,
  output logic [DW-1:0]            res_o
);
  import tta_pkg::*;

  logic [DW-1:0] addr_q, addr_d, tval, res_q;
  logic          st, ld;

  always_comb begin
    addr_d = addr_q;
    st     = 1'b0;
    ld     = 1'b0;
    tval   = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (slot_vld_i[s] && slot_dst_i[s] == DST_LADDR) addr_d = slot_val_i[s];
      if (slot_vld_i[s] && (slot_dst_i[s] == DST_STORE || slot_dst_i[s] == DST_LOAD)) begin
        st   = slot_dst_i[s] == DST_STORE;
        ld   = slot_dst_i[s] == DST_LOAD;
        tval = slot_val_i[s];
      end
    end
  end

  assign mem_we_o    = st;
  assign mem_re_o    = ld;
  assign mem_addr_o  = ld ? tval : addr_d;
  assign mem_wdata_o = st ? tval : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      res_q  <= '0;
    end else begin
      addr_q <= addr_d;
      if (ld) res_q <= mem_rdata_i;
    end
  end

  assign res_o = res_q;
endmodule

// File: rtl/tta_core.sv
module tta_core #(
  parameter int  NREG    = 8,  // at most 8: ids 8.. are result ports
  parameter int  DW      = 32,
  parameter int  SLOTS   = 4,
  localparam int AW      = $clog2(NREG),
  localparam int INSTR_W = SLOTS * tta_pkg::SLOT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  output logic [DW-1:0]      mem_addr_o,
  output logic [DW-1:0]      mem_wdata_o,
  output logic               mem_we_o,
  output logic               mem_re_o,
  input  logic [DW-1:0]      mem_rdata_i,
  input  logic [AW-1:0]      dbg_addr_i,
  output logic [DW-1:0]      dbg_data_o
);
  import tta_pkg::*;

  logic            slot_vld [SLOTS];
  logic [ID_W-1:0] slot_src [SLOTS];
  logic [ID_W-1:0] slot_dst [SLOTS];
  logic [DW-1:0]   slot_val [SLOTS];
  logic [AW-1:0]   rd_addr  [SLOTS];
  logic [DW-1:0]   rd_data  [SLOTS];

  logic [1:0]          alu_trg;
  logic [1:0][DW-1:0]  alu_res;
  logic [DW-1:0]       lsu_res;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [SLOT_W-1:0] slot;
    assign slot        = instr_i[g*SLOT_W +: SLOT_W];
    assign slot_vld[g] = slot[SLOT_W-1];
    assign slot_src[g] = slot[2*ID_W-1:ID_W];
    assign slot_dst[g] = slot[ID_W-1:0];
    assign rd_addr[g]  = slot_src[g][AW-1:0];

    tta_src_mux #(.NREG(NREG), .DW(DW)) u_mux (
      .src_i  (slot_src[g]),
      .reg_i  (rd_data[g]),
      .alu0_i (alu_res[0]),
      .alu1_i (alu_res[1]),
      .lsu_i  (lsu_res),
      .val_o  (slot_val[g])
    );
  end

  tta_rf #(.NREG(NREG), .DW(DW), .SLOTS(SLOTS)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slot_vld_i (slot_vld),
    .slot_dst_i (slot_dst),
    .slot_val_i (slot_val),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .dbg_addr_i (dbg_addr_i),
    .dbg_data_o (dbg_data_o)
  );

  for (genvar u = 0; u < 2; u++) begin : g_alu
    tta_fu_alu #(
      .DW     (DW),
      .SLOTS  (SLOTS),
      .OPA_ID (u == 0 ? DST_OPA0 : DST_OPA1),
      .TRG_ID (u == 0 ? DST_TRG0 : DST_TRG1)
    ) u_alu (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .slot_vld_i (slot_vld),
      .slot_dst_i (slot_dst),
      .slot_val_i (slot_val),
      .trg_o      (alu_trg[u]),
      .res_o      (alu_res[u])
    );
  end

  tta_fu_lsu #(.DW(DW), .SLOTS(SLOTS)) u_lsu (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slot_vld_i  (slot_vld),
    .slot_dst_i  (slot_dst),
    .slot_val_i  (slot_val),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .mem_rdata_i (mem_rdata_i),
    .res_o       (lsu_res)
  );
endmodule

// File: rtl/tta_core_chk.sv
module tta_core_chk #(
  parameter int DW = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                mem_we_o,
  input logic                mem_re_o,
  input logic [DW-1:0]       mem_rdata_i,
  input logic [1:0]          alu_trg,
  input logic [1:0][DW-1:0]  alu_res,
  input logic [DW-1:0]       lsu_res
);
  AST_ST_LD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !mem_re_o); // R9
  AST_LD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> lsu_res == $past(mem_rdata_i)); // R9
  AST_ALU0_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alu_trg[0] |=> $stable(alu_res[0])); // R7
  AST_ALU1_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alu_trg[1] |=> $stable(alu_res[1])); // R7
  AST_LSU_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_re_o |=> $stable(lsu_res)); // R7
endmodule

bind tta_core tta_core_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_we_o    (mem_we_o),
  .mem_re_o    (mem_re_o),
  .mem_rdata_i (mem_rdata_i),
  .alu_trg     (alu_trg),
  .alu_res     (alu_res),
  .lsu_res     (lsu_res)
);

// File: tb/sim_tta_core.sv
module sim_tta_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [51:0] instr = '0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, dbg_data;
  logic        mem_we, mem_re;
  logic [2:0]  dbg_addr = '0;
  logic [31:0] mem [16];

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    bit          is_mem;
    int          idx;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  tta_core u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .instr_i     (instr),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_we_o    (mem_we),
    .mem_re_o    (mem_re),
    .mem_rdata_i (mem_rdata),
    .dbg_addr_i  (dbg_addr),
    .dbg_data_o  (dbg_data)
  );

  assign mem_rdata = mem[mem_addr[3:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[3:0]] <= mem_wdata;

  function automatic logic [12:0] mv(int src, int dst);
    return {1'b1, src[5:0], dst[5:0]};
  endfunction

  function automatic logic [51:0] ins(logic [12:0] s0, logic [12:0] s1 = '0,
                                      logic [12:0] s2 = '0, logic [12:0] s3 = '0);
    return {s3, s2, s1, s0};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(logic [51:0] w);
    @(negedge clk);
    instr = w;
  endtask

  task automatic drain();
    @(negedge clk);
    instr = '0;
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic exp_reg(int idx, logic [31:0] v, string tag);
    item_t it;
    it.is_mem = 0; it.idx = idx; it.exp = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic exp_mem(int idx, logic [31:0] v, string tag);
    item_t it;
    it.is_mem = 1; it.idx = idx; it.exp = v; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compares queued expectations while the driver holds idle words
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() != 0) begin
        if (!q[0].is_mem) begin
          dbg_addr = q[0].idx[2:0];
          #1;
          chk(q[0].tag, dbg_data, q[0].exp);
        end else begin
          chk(q[0].tag, mem[q[0].idx], q[0].exp);
        end
        void'(q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'(100 + 3 * i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of registers and result ports
    issue(ins(mv(37, 1), mv(37, 2), mv(37, 3)));
    issue(ins(mv(8, 1), mv(9, 2), mv(10, 3)));
    drain();
    exp_reg(0, 0, "R1 r0"); exp_reg(7, 0, "R1 r7");
    exp_reg(1, 0, "R1 alu0 result"); exp_reg(2, 0, "R1 alu1 result");
    exp_reg(3, 0, "R1 lsu result");
    drain();

    // R3 immediates
    issue(ins(mv(39, 0), mv(63, 1), mv(32, 2), mv(44, 3)));
    drain();
    exp_reg(0, 7, "R3 imm 7"); exp_reg(1, 31, "R3 imm 31");
    exp_reg(3, 12, "R3 imm 12 R10 debug read");
    drain();

    // R2: invalid slot 0 ignored, slot 3 position decoded
    issue(ins({1'b0, 6'd33, 6'd0}, '0, '0, mv(40, 4)));
    drain();
    exp_reg(0, 7, "R2 invalid slot"); exp_reg(4, 8, "R2 slot3");
    drain();

    // R4 swap
    issue(ins(mv(0, 1), mv(1, 0)));
    drain();
    exp_reg(0, 31, "R4 swap r0"); exp_reg(1, 7, "R4 swap r1");
    drain();

    // R5/R7: parallel add and sub
    issue(ins(mv(0, 8), mv(1, 16), mv(0, 9), mv(1, 25)));
    issue(ins(mv(8, 4), mv(9, 5)));
    drain();
    exp_reg(4, 38, "R5 add"); exp_reg(5, 24, "R5 sub R7 read");
    drain();

    // R6 operand A retained
    issue(ins(mv(35, 20)));
    issue(ins(mv(8, 6)));
    drain();
    exp_reg(6, 28, "R6 retained xor");
    drain();

    // R7 bypass result into other unit, then hold
    issue(ins(mv(8, 9), mv(36, 29)));
    issue(ins(mv(9, 7)));
    issue('0); issue('0); issue('0);
    issue(ins(mv(9, 2)));
    drain();
    exp_reg(7, 448, "R7 bypass shl"); exp_reg(2, 448, "R7 hold");
    drain();

    // R8 same destination and same-unit triggers
    issue(ins(mv(33, 3), mv(33, 16), mv(34, 3), mv(34, 17)));
    issue(ins(mv(8, 6)));
    drain();
    exp_reg(3, 2, "R8 reg priority"); exp_reg(6, 29, "R8 trigger priority");
    drain();

    // R5 remaining ops on second ALU, chained
    issue(ins(mv(35, 27)));
    issue(ins(mv(9, 0), mv(34, 30)));
    issue(ins(mv(9, 1), mv(63, 31)));
    issue(ins(mv(9, 2), mv(44, 26)));
    issue(ins(mv(9, 3)));
    drain();
    exp_reg(0, 31, "R5 or"); exp_reg(1, 7, "R5 shr");
    exp_reg(2, 1, "R5 sltu"); exp_reg(3, 12, "R5 and");
    drain();

    // R6 same-instruction operand forward
    issue(ins(mv(42, 8), mv(35, 17)));
    issue(ins(mv(8, 4)));
    drain();
    exp_reg(4, 7, "R6 forward");
    drain();

    // R9 store, port values during the instruction
    issue(ins(mv(37, 10), mv(52, 32)));
    #1;
    chk("R9 store we", 32'(mem_we), 1);
    chk("R9 store re", 32'(mem_re), 0);
    chk("R9 store addr", mem_addr, 5);
    chk("R9 store data", mem_wdata, 20);
    drain();
    exp_mem(5, 20, "R9 memory written");
    drain();

    // R9 loads
    issue(ins(mv(37, 33)));
    #1;
    chk("R9 load re", 32'(mem_re), 1);
    chk("R9 load addr", mem_addr, 5);
    issue(ins(mv(10, 0)));
    issue(ins(mv(34, 33)));
    issue(ins(mv(10, 1)));
    drain();
    exp_reg(0, 20, "R9 load back"); exp_reg(1, 106, "R9 load init");
    drain();

    // R3 unused source ids
    issue(ins(mv(11, 5), mv(20, 6)));
    drain();
    exp_reg(5, 0, "R3 id11"); exp_reg(6, 0, "R3 id20");
    drain();

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule